// File: doc/BRIEF.md
# USB Bulk OUT Receive Controller

This block runs the device side of a bulk OUT transaction for one endpoint. A serial interface engine in front of it does the line decoding and the CRC arithmetic. It passes in decoded token fields: the token kind, an address/endpoint match, and an address/endpoint error flag. It then passes the data packet as a byte stream, with a start strobe that carries the DATA0/DATA1 PID bit and an end strobe that carries the CRC verdict. The block writes the payload into a receive FIFO and decides which handshake to send. It also keeps the expected data toggle, the size of the last good packet, a data-ready flag and an endpoint status code.

Every failure class leads to its own status code and its own handshake choice. On every failure the FIFO write pointer is wound back to where it stood at packet start. The consumer therefore only ever sees whole, accepted packets. A DATA PID that does not match the expected toggle is taken as a resend after a lost ACK. The packet is dropped, but it is still acknowledged so that the host can move on.

Top module: `bulk_out_rx`

## Requirements
- R1: A token is ignored when it is not OUT, when the match flag is low, when the error flag is high, or when the endpoint is not configured for bulk OUT (`cfg_bulk_out`=0). The data packet that follows it then produces no handshake and no change to the FIFO level or the status.
- R2: With `cfg_stall`=1 at packet start, the whole data phase is consumed. One cycle after `pkt_end`, `hs_valid` pulses with `hs_code`=2 (STALL). FIFO level, status and toggle stay unchanged.
- R3: When the free FIFO space at packet start is smaller than the maximum payload, the bytes are dropped and `hs_code`=1 (NAK) pulses one cycle after `pkt_end`. The FIFO never holds more than DEPTH bytes.
- R4: The maximum payload is 8 << `cfg_max_sel` bytes (8, 16, 32, 64). When a byte arrives after that many bytes, the packet is dropped, no handshake is sent, and status becomes 4 (HALT).
- R5: When `pkt_crc_ok`=0 at `pkt_end`, the packet is dropped, no handshake is sent, and status becomes 3 (RX_ERR).
- R6: When the PID bit differs from `exp_toggle`, the packet is dropped, ACK (`hs_code`=0) is still sent, status becomes 3 (RX_ERR), and the toggle stays unchanged.
- R7: A good packet leads to the following one cycle after `pkt_end`: ACK (`hs_code`=0), `data_size` = the byte count, `data_set`=1, `exp_toggle` inverted, and status 1 (READY).
- R8: A good packet received while status is 3 or 4 sets status to 2 (DATIN) instead of 1.
- R9: A `toggle_clr` pulse makes `exp_toggle` 0 (DATA0) on the next cycle.
- R10: `rd_level` rises only when a good packet is committed, by its full size. Dropped packets leave no byte in the FIFO.
- R11: `rd_en` while `rd_level`>0 gives the oldest byte on `rd_data` with `rd_valid`=1 one cycle later, and `rd_level` drops by one. `data_ack` clears `data_set`.
- R12: After reset: status 0 (NONE), `exp_toggle` 0, `rd_level` 0, `data_set` 0, `hs_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | One-cycle strobe: a token has been decoded |
| tok_is_out | input | 1 | Token kind is OUT |
| tok_match | input | 1 | Address and endpoint match this endpoint |
| tok_err | input | 1 | Address/endpoint field error |
| cfg_bulk_out | input | 1 | Endpoint configured for bulk OUT |
| cfg_stall | input | 1 | Endpoint in stall condition |
| cfg_max_sel | input | 2 | Maximum payload select: 8 << value bytes |
| toggle_clr | input | 1 | Reset expected toggle to DATA0 |
| pkt_start | input | 1 | Data packet start strobe |
| pkt_pid1 | input | 1 | PID bit of the packet, valid with pkt_start (1 = DATA1) |
| pkt_valid | input | 1 | Payload byte strobe |
| pkt_byte | input | 8 | Payload byte |
| pkt_end | input | 1 | Packet end strobe (carries no byte) |
| pkt_crc_ok | input | 1 | CRC verdict, valid with pkt_end |
| data_ack | input | 1 | Consumer clears data_set |
| rd_en | input | 1 | FIFO read request |
| hs_valid | output | 1 | Handshake request pulse |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| ep_status | output | 3 | 0 NONE, 1 READY, 2 DATIN, 3 RX_ERR, 4 HALT |
| data_size | output | 7 | Byte count of the last accepted packet |
| data_set | output | 1 | Accepted packet waiting |
| exp_toggle | output | 1 | Expected PID bit of the next packet |
| rd_valid | output | 1 | rd_data holds a byte read out |
| rd_data | output | 8 | FIFO read data |
| rd_level | output | 8 | Committed bytes in the FIFO |

## Verification
Properties inside the RTL check on every cycle the following: an ignored token leaves the sequencer idle; the stall reply and the silent drops on overflow and on CRC failure; the acknowledged resend that holds the toggle; that writes never overrun unread bytes; and that the committed level never grows without a commit. A behavioural model in the bench, built on queues, follows the FIFO contents, status, toggle and handshakes cycle by cycle. Only that model and the directed scenarios can show certain things: the order of the status code change from error to DATIN, that dropped packets leave the FIFO contents in byte order, and the full-FIFO NAK boundary at exactly DEPTH bytes.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RECV} seq_t;
  typedef enum logic [1:0] {M_TAKE, M_NAK, M_STALL} mode_t;

  localparam logic [1:0] HS_ACK   = 2'd0;
  localparam logic [1:0] HS_NAK   = 2'd1;
  localparam logic [1:0] HS_STALL = 2'd2;

  localparam logic [2:0] EP_NONE  = 3'd0;
  localparam logic [2:0] EP_READY = 3'd1;
  localparam logic [2:0] EP_DATIN = 3'd2;
  localparam logic [2:0] EP_RXERR = 3'd3;
  localparam logic [2:0] EP_HALT  = 3'd4;
endpackage

// File: rtl/bor_rxfifo.sv
module bor_rxfifo #(
  parameter int DEPTH = 128,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rewind,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   level,
  output logic [AW:0]   space
);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, cmt_ptr, rd_ptr;
  logic          rd_go;

  assign level = cmt_ptr - rd_ptr;
  assign space = CAP - level;
  assign rd_go = rd_en && (level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      cmt_ptr  <= '0;
      rd_ptr   <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (rewind)     wr_ptr <= cmt_ptr;
      else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (commit)     cmt_ptr <= wr_ptr;
      if (rd_go)      rd_ptr <= rd_ptr + 1'b1;
      rd_valid <= rd_go;
    end
  end

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    if (rd_go) rd_data <= mem[rd_ptr[AW-1:0]];
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    level <= CAP);

  p_write_room_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_ptr - rd_ptr) < CAP));

  p_hidden_partial_r10: assert property (@(posedge clk) disable iff (rst)
    !commit |=> (level <= $past(level)));
endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
  import bor_pkg::*;
#(
  parameter int MAXPKT = 64,
  parameter int AW = 7,
  localparam int CW = $clog2(MAXPKT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  input  logic          tok_is_out,
  input  logic          tok_match,
  input  logic          tok_err,
  input  logic          cfg_bulk_out,
  input  logic          cfg_stall,
  input  logic [1:0]    cfg_max_sel,
  input  logic          toggle_clr,
  input  logic          pkt_start,
  input  logic          pkt_pid1,
  input  logic          pkt_valid,
  input  logic          pkt_end,
  input  logic          pkt_crc_ok,
  input  logic          data_ack,
  input  logic [AW:0]   fifo_space,
  output logic          wr_en,
  output logic          commit,
  output logic          rewind,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic [2:0]    ep_status,
  output logic [CW-1:0] data_size,
  output logic          data_set,
  output logic          exp_toggle
);
  seq_t          state;
  mode_t         mode;
  logic          pid_q;
  logic          ovf;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_max;
  logic [CW-1:0] lim;
  logic          accept;
  logic          end_evt;
  logic          good;
  logic          room_short;

  always_comb begin
    int unsigned raw;
    raw = 32'd8 << cfg_max_sel;
    lim = (raw > MAXPKT) ? CW'(MAXPKT) : CW'(raw);
  end

  assign room_short = int'(fifo_space) < int'(lim);
  assign accept  = tok_is_out && tok_match && !tok_err && cfg_bulk_out;
  assign end_evt = (state == S_RECV) && pkt_end;
  assign good    = end_evt && (mode == M_TAKE) && !ovf && pkt_crc_ok
                   && (pid_q == exp_toggle);
  assign wr_en   = (state == S_RECV) && pkt_valid && !pkt_end
                   && (mode == M_TAKE) && !ovf && (cnt < cur_max);
  assign commit  = good;
  assign rewind  = end_evt && !good;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mode      <= M_TAKE;
      pid_q     <= 1'b0;
      ovf       <= 1'b0;
      cnt       <= '0;
      cur_max   <= '0;
      hs_valid  <= 1'b0;
      hs_code   <= HS_ACK;
      ep_status <= EP_NONE;
      data_size <= '0;
      data_set  <= 1'b0;
    end else begin
      hs_valid <= 1'b0;
      if (data_ack) data_set <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tok_valid && accept) state <= S_WAIT;
        end
        S_WAIT: begin
          if (pkt_start) begin
            state   <= S_RECV;
            pid_q   <= pkt_pid1;
            cnt     <= '0;
            ovf     <= 1'b0;
            cur_max <= lim;
            if (cfg_stall)       mode <= M_STALL;
            else if (room_short) mode <= M_NAK;
            else                 mode <= M_TAKE;
          end
        end
        S_RECV: begin
          if (pkt_end) begin
            state <= S_IDLE;
            case (mode)
              M_STALL: begin
                hs_valid <= 1'b1;
                hs_code  <= HS_STALL;
              end
              M_NAK: begin
                hs_valid <= 1'b1;
                hs_code  <= HS_NAK;
              end
              default: begin
                if (ovf) begin
                  ep_status <= EP_HALT;
                end else if (!pkt_crc_ok) begin
                  ep_status <= EP_RXERR;
                end else if (pid_q != exp_toggle) begin
                  ep_status <= EP_RXERR;
                  hs_valid  <= 1'b1;
                  hs_code   <= HS_ACK;
                end else begin
                  hs_valid  <= 1'b1;
                  hs_code   <= HS_ACK;
                  data_size <= cnt;
                  data_set  <= 1'b1;
                  ep_status <= (ep_status == EP_RXERR || ep_status == EP_HALT)
                               ? EP_DATIN : EP_READY;
                end
              end
            endcase
          end else if (pkt_valid && (mode == M_TAKE) && !ovf) begin
            if (cnt == cur_max) ovf <= 1'b1;
            else                cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             exp_toggle <= 1'b0;
    else if (toggle_clr) exp_toggle <= 1'b0;
    else if (good)       exp_toggle <= ~exp_toggle;
  end

  p_ignore_tok_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && tok_valid && !accept) |=> (state == S_IDLE));

  p_stall_reply_r2: assert property (@(posedge clk) disable iff (rst)
    (end_evt && mode == M_STALL) |=> (hs_valid && hs_code == HS_STALL));

  p_ovf_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (end_evt && mode == M_TAKE && ovf) |=> (!hs_valid && ep_status == EP_HALT));

  p_crc_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (end_evt && mode == M_TAKE && !ovf && !pkt_crc_ok)
      |=> (!hs_valid && ep_status == EP_RXERR));

  p_retry_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (end_evt && mode == M_TAKE && !ovf && pkt_crc_ok && pid_q != exp_toggle && !toggle_clr)
      |=> (hs_valid && hs_code == HS_ACK && $stable(exp_toggle)));

  p_good_flag_r7: assert property (@(posedge clk) disable iff (rst)
    good |=> (data_set && hs_valid && hs_code == HS_ACK));

  p_toggle_clr_r9: assert property (@(posedge clk) disable iff (rst)
    toggle_clr |=> !exp_toggle);
endmodule

// File: rtl/bulk_out_rx.sv
module bulk_out_rx #(
  parameter int DEPTH = 128,
  parameter int MAXPKT = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(MAXPKT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  input  logic          tok_is_out,
  input  logic          tok_match,
  input  logic          tok_err,
  input  logic          cfg_bulk_out,
  input  logic          cfg_stall,
  input  logic [1:0]    cfg_max_sel,
  input  logic          toggle_clr,
  input  logic          pkt_start,
  input  logic          pkt_pid1,
  input  logic          pkt_valid,
  input  logic [7:0]    pkt_byte,
  input  logic          pkt_end,
  input  logic          pkt_crc_ok,
  input  logic          data_ack,
  input  logic          rd_en,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic [2:0]    ep_status,
  output logic [CW-1:0] data_size,
  output logic          data_set,
  output logic          exp_toggle,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic [AW:0]   rd_level
);
  logic        wr_en, commit, rewind;
  logic [AW:0] space;

  bor_ctrl #(.MAXPKT(MAXPKT), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .tok_valid(tok_valid), .tok_is_out(tok_is_out), .tok_match(tok_match),
    .tok_err(tok_err), .cfg_bulk_out(cfg_bulk_out), .cfg_stall(cfg_stall),
    .cfg_max_sel(cfg_max_sel), .toggle_clr(toggle_clr),
    .pkt_start(pkt_start), .pkt_pid1(pkt_pid1), .pkt_valid(pkt_valid),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .data_ack(data_ack),
    .fifo_space(space), .wr_en(wr_en), .commit(commit), .rewind(rewind),
    .hs_valid(hs_valid), .hs_code(hs_code), .ep_status(ep_status),
    .data_size(data_size), .data_set(data_set), .exp_toggle(exp_toggle)
  );

  bor_rxfifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_data(pkt_byte), .commit(commit), .rewind(rewind),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .level(rd_level), .space(space)
  );
endmodule

// File: tb/bulk_out_rx_tb.sv
module bulk_out_rx_tb;
  localparam int DEPTH = 128;
  localparam int MAXPKT = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_valid = 0, tok_is_out = 0, tok_match = 0, tok_err = 0;
  logic cfg_bulk_out = 1, cfg_stall = 0;
  logic [1:0] cfg_max_sel = 2'd3;
  logic toggle_clr = 0;
  logic pkt_start = 0, pkt_pid1 = 0, pkt_valid = 0, pkt_end = 0, pkt_crc_ok = 0;
  logic [7:0] pkt_byte = 0;
  logic data_ack = 0, rd_en = 0;
  logic hs_valid, data_set, exp_toggle, rd_valid;
  logic [1:0] hs_code;
  logic [2:0] ep_status;
  logic [6:0] data_size;
  logic [7:0] rd_data;
  logic [7:0] rd_level;

  int n_chk = 0, n_fail = 0;
  int last_hsv, last_hsc;

  always #5 clk = ~clk;

  bulk_out_rx #(.DEPTH(DEPTH), .MAXPKT(MAXPKT)) u_dut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_is_out(tok_is_out),
    .tok_match(tok_match), .tok_err(tok_err), .cfg_bulk_out(cfg_bulk_out),
    .cfg_stall(cfg_stall), .cfg_max_sel(cfg_max_sel), .toggle_clr(toggle_clr),
    .pkt_start(pkt_start), .pkt_pid1(pkt_pid1), .pkt_valid(pkt_valid),
    .pkt_byte(pkt_byte), .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
    .data_ack(data_ack), .rd_en(rd_en), .hs_valid(hs_valid), .hs_code(hs_code),
    .ep_status(ep_status), .data_size(data_size), .data_set(data_set),
    .exp_toggle(exp_toggle), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_level(rd_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state, m_mode, m_pid, m_cnt, m_ovf, m_tog, m_status, m_dsize, m_dset;
  int m_hsv, m_hsc, m_max, m_rdv, m_rdd;
  logic [7:0] mq[$];
  logic [7:0] pq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_mode = 0; m_pid = 0; m_cnt = 0; m_ovf = 0; m_tog = 0;
      m_status = 0; m_dsize = 0; m_dset = 0; m_hsv = 0; m_hsc = 0; m_max = 0;
      m_rdv = 0; m_rdd = 0;
      mq.delete(); pq.delete();
    end else begin
      int sz0;
      bit ok_pkt;
      ok_pkt = 0;
      sz0 = mq.size();
      m_hsv = 0;
      m_rdv = 0;
      if (rd_en && sz0 > 0) begin
        m_rdd = int'(mq.pop_front());
        m_rdv = 1;
      end
      if (data_ack) m_dset = 0;
      if (m_state == 0) begin
        if (tok_valid && tok_is_out && tok_match && !tok_err && cfg_bulk_out) m_state = 1;
      end else if (m_state == 1) begin
        if (pkt_start) begin
          m_state = 2; m_pid = int'(pkt_pid1); m_cnt = 0; m_ovf = 0; pq.delete();
          m_max = 8 << cfg_max_sel;
          if (m_max > MAXPKT) m_max = MAXPKT;
          if (cfg_stall) m_mode = 2;
          else if (DEPTH - sz0 < m_max) m_mode = 1;
          else m_mode = 0;
        end
      end else begin
        if (pkt_end) begin
          m_state = 0;
          if (m_mode == 2) begin m_hsv = 1; m_hsc = 2; end
          else if (m_mode == 1) begin m_hsv = 1; m_hsc = 1; end
          else if (m_ovf) m_status = 4;
          else if (!pkt_crc_ok) m_status = 3;
          else if (m_pid != m_tog) begin m_status = 3; m_hsv = 1; m_hsc = 0; end
          else begin
            ok_pkt = 1; m_hsv = 1; m_hsc = 0; m_dsize = m_cnt; m_dset = 1;
            m_status = (m_status == 3 || m_status == 4) ? 2 : 1;
            foreach (pq[i]) mq.push_back(pq[i]);
          end
          pq.delete();
        end else if (pkt_valid && m_mode == 0 && !m_ovf) begin
          if (m_cnt < m_max) begin pq.push_back(pkt_byte); m_cnt++; end
          else m_ovf = 1;
        end
      end
      if (toggle_clr) m_tog = 0;
      else if (ok_pkt) m_tog = 1 - m_tog;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 model hs_valid", int'(hs_valid), m_hsv);
      if (m_hsv != 0) chk("R7 model hs_code", int'(hs_code), m_hsc);
      chk("R8 model ep_status", int'(ep_status), m_status);
      chk("R7 model data_size", int'(data_size), m_dsize);
      chk("R11 model data_set", int'(data_set), m_dset);
      chk("R9 model exp_toggle", int'(exp_toggle), m_tog);
      chk("R10 model rd_level", int'(rd_level), mq.size());
      chk("R11 model rd_valid", int'(rd_valid), m_rdv);
      if (m_rdv != 0) chk("R11 model rd_data", int'(rd_data), m_rdd);
    end
  end

  // ---------------- stimulus tasks (start and end at a negedge) ----------------
  task automatic tok(input bit is_out, input bit match, input bit err);
    tok_valid = 1; tok_is_out = is_out; tok_match = match; tok_err = err;
    @(negedge clk);
    tok_valid = 0; tok_is_out = 0; tok_match = 0; tok_err = 0;
  endtask

  task automatic pkt(input bit pid, input int n, input bit crc, input int base);
    pkt_start = 1; pkt_pid1 = pid;
    @(negedge clk);
    pkt_start = 0;
    for (int i = 0; i < n; i++) begin
      pkt_valid = 1; pkt_byte = 8'(base + i);
      @(negedge clk);
    end
    pkt_valid = 0; pkt_end = 1; pkt_crc_ok = crc;
    @(negedge clk);
    pkt_end = 0; pkt_crc_ok = 0;
    last_hsv = int'(hs_valid);
    last_hsc = int'(hs_code);
    @(negedge clk);
  endtask

  task automatic xfer(input bit pid, input int n, input bit crc, input int base);
    tok(1, 1, 0);
    pkt(pid, n, crc, base);
  endtask

  task automatic drain(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      chk("R11 read valid", int'(rd_valid), 1);
      chk("R11 read byte", int'(rd_data), (base + i) & 255);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 reset status", int'(ep_status), 0);
    chk("R12 reset toggle", int'(exp_toggle), 0);
    chk("R12 reset level", int'(rd_level), 0);
    chk("R12 reset data_set", int'(data_set), 0);
    chk("R12 reset hs_valid", int'(hs_valid), 0);

    // R1: ignored tokens of each kind
    tok(0, 1, 0); pkt(0, 4, 1, 8'h10);
    chk("R1 non-OUT no hs", last_hsv, 0);
    tok(1, 1, 1); pkt(0, 4, 1, 8'h10);
    chk("R1 error flag no hs", last_hsv, 0);
    tok(1, 0, 0); pkt(0, 4, 1, 8'h10);
    chk("R1 no match no hs", last_hsv, 0);
    cfg_bulk_out = 0;
    tok(1, 1, 0); pkt(0, 4, 1, 8'h10);
    cfg_bulk_out = 1;
    chk("R1 not bulk OUT no hs", last_hsv, 0);
    chk("R1 level untouched", int'(rd_level), 0);
    chk("R1 status untouched", int'(ep_status), 0);

    // R7: good DATA0 packet
    xfer(0, 5, 1, 8'h20);
    chk("R7 ack sent", last_hsv, 1);
    chk("R7 ack code", last_hsc, 0);
    chk("R7 status READY", int'(ep_status), 1);
    chk("R7 data_size", int'(data_size), 5);
    chk("R7 data_set", int'(data_set), 1);
    chk("R7 toggle inverted", int'(exp_toggle), 1);
    chk("R10 level after commit", int'(rd_level), 5);

    // R11: read back and acknowledge
    drain(5, 8'h20);
    data_ack = 1; @(negedge clk); data_ack = 0; @(negedge clk);
    chk("R11 data_set cleared", int'(data_set), 0);
    chk("R11 level empty", int'(rd_level), 0);

    // R6: resend with stale PID
    xfer(0, 4, 1, 8'h30);
    chk("R6 ack on resend", last_hsv, 1);
    chk("R6 ack code", last_hsc, 0);
    chk("R6 status RX_ERR", int'(ep_status), 3);
    chk("R6 toggle held", int'(exp_toggle), 1);
    chk("R6 nothing stored", int'(rd_level), 0);

    // R8: good packet after error
    xfer(1, 3, 1, 8'h40);
    chk("R8 status DATIN", int'(ep_status), 2);
    chk("R8 toggle", int'(exp_toggle), 0);
    chk("R8 level", int'(rd_level), 3);

    // R5: CRC failure
    xfer(0, 4, 0, 8'h50);
    chk("R5 no handshake", last_hsv, 0);
    chk("R5 status RX_ERR", int'(ep_status), 3);
    chk("R5 level rewound", int'(rd_level), 3);
    chk("R5 toggle held", int'(exp_toggle), 0);

    // R4: overflow at 8-byte limit, then exact limit
    cfg_max_sel = 2'd0;
    xfer(0, 9, 1, 8'h60);
    chk("R4 no handshake", last_hsv, 0);
    chk("R4 status HALT", int'(ep_status), 4);
    chk("R4 level rewound", int'(rd_level), 3);
    xfer(0, 8, 1, 8'h70);
    chk("R4 exact limit ack", last_hsv, 1);
    chk("R4 exact size", int'(data_size), 8);
    chk("R8 DATIN after HALT", int'(ep_status), 2);
    drain(3, 8'h40);
    drain(8, 8'h70);

    // R3: full FIFO leads to NAK
    cfg_max_sel = 2'd3;
    xfer(1, 64, 1, 8'h00);
    chk("R3 first 64 ack", last_hsv, 1);
    xfer(0, 64, 1, 8'h80);
    chk("R3 second 64 ack", last_hsv, 1);
    chk("R3 level full", int'(rd_level), 128);
    xfer(1, 10, 1, 8'h90);
    chk("R3 nak sent", last_hsv, 1);
    chk("R3 nak code", last_hsc, 1);
    chk("R3 level unchanged", int'(rd_level), 128);
    chk("R3 toggle held", int'(exp_toggle), 1);
    drain(64, 8'h00);
    drain(64, 8'h80);

    // R2: stall condition
    cfg_stall = 1;
    xfer(1, 6, 1, 8'hA0);
    cfg_stall = 0;
    chk("R2 stall sent", last_hsv, 1);
    chk("R2 stall code", last_hsc, 2);
    chk("R2 level unchanged", int'(rd_level), 0);
    chk("R2 status unchanged", int'(ep_status), 1);
    chk("R2 toggle held", int'(exp_toggle), 1);

    // R9: toggle reset to DATA0
    toggle_clr = 1; @(negedge clk); toggle_clr = 0;
    chk("R9 toggle cleared", int'(exp_toggle), 0);
    xfer(0, 2, 1, 8'hB0);
    chk("R9 DATA0 accepted", int'(data_size), 2);
    chk("R9 toggle after", int'(exp_toggle), 1);
    drain(2, 8'hB0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule